// File: doc/BRIEF.md
# Serial Audio Master Transmitter

This block sends 16-bit stereo audio words as a two-channel serial stream with Philips-style framing. It generates the bit clock and the word-select line on its own. A host hands it one half-word at a time through a write strobe. The block has a single-entry holding buffer in front of a 16-bit shift register. The word in the shifter goes out on the data line most significant bit first. Data changes on the falling edge of the internal bit clock, so with polarity 0 a receiver samples it on the rising edge of the serial clock.

The host paces itself with three flags. The buffer-empty flag tells it when it may write. The channel-side flag tells it whether the next word it writes is a left or a right sample. The busy flag tells it when the stream has fully drained. An interrupt request is raised whenever the buffer is empty and the interrupt enable is set.

A word written while the shifter is idle moves into the shifter on the next cycle. A word written while the shifter is busy waits in the buffer until the current word finishes. At that moment it is loaded, and the next word follows the current one with no gap. The enable input is meant to be cleared only once the buffer is empty and the busy flag is low.

Top module: `i2s_tx_master`

## Requirements
- R1: After reset, and after the enable input is set, the outputs settle as follows: tx_empty is 1, busy is 0, chan_side is 0, sd is 0 and irq is 0 while irq_en is 0.
- R2: A write strobe while the shifter is idle clears tx_empty for exactly one cycle. tx_empty reads 0 one cycle after the strobe and reads 1 again one cycle later.
- R3: Each word is sent as 16 bits on sd, bit 15 first. When cfg_cpol is 0, each bit is valid at the rising edge of sck.
- R4: A word written while another word is shifting stays in the buffer, so tx_empty stays 0 until the current word ends. It is then sent directly after the current word, and busy does not drop between the two words.
- R5: chan_side starts at 0, which means the next word written is for the left channel. It toggles exactly in the cycles where tx_empty rises and holds its value at all other times.
- R6: ws is 0 for a left word and 1 for a right word. ws already carries the word's value during the bit period before the word's bit 15, and it keeps that value during bit 15.
- R7: The sck period is 2*(2*D+cfg_odd) cycles of clk, where D is cfg_div, except that a cfg_div value below 2 counts as 2.
- R8: While cfg_en is 0, sck rests at the level given by cfg_cpol.
- R9: busy rises when bit 15 of a word is driven and falls when the last bit ends with no word pending. For a single isolated word, busy stays high for 16 sck periods. sd is 0 while busy is low.
- R10: irq is 1 exactly when irq_en is 1 and tx_empty is 1.
- R11: Write strobes are ignored while cfg_en is 0. Clearing cfg_en returns chan_side to 0 and empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Transmitter enable; clearing it returns the block to its start state |
| cfg_div | input | 8 | Bit-clock divider value |
| cfg_odd | input | 1 | Adds one clk cycle to each half of the bit-clock period |
| cfg_cpol | input | 1 | Resting level of sck |
| irq_en | input | 1 | Enable for the buffer-empty interrupt |
| wr_stb | input | 1 | Write strobe for the data word |
| wr_data | input | 16 | Audio half-word to send |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select (0 left, 1 right) |
| sd | output | 1 | Serial data, most significant bit first |
| tx_empty | output | 1 | Holding buffer is empty |
| chan_side | output | 1 | Channel of the next word to write (0 left, 1 right) |
| busy | output | 1 | A word is being shifted out |
| irq | output | 1 | Interrupt request |

## Verification
A wrong handoff between the buffer and the shifter shows up within one word time: a stale or lost word in the received stream, or a busy drop between back-to-back words. A channel-side flag that toggles at the wrong time shows up as a word-select level that does not match the expected channel in the bit period before bit 15. The same error also appears as a chan_side change that is not aligned with the rising edge of tx_empty. A wrong divider is seen in the first measured sck period, and a wrong idle-load path breaks the one-cycle empty pulse two cycles after the write strobe.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_ARM   = 2'd1,
    SH_LEAD  = 2'd2,
    SH_SHIFT = 2'd3
  } sh_state_t;

  // clk cycles in one half of a bit-clock period
  function automatic int unsigned half_cycles(input int unsigned div,
                                              input bit odd,
                                              input int unsigned min_div);
    int unsigned d;
    d = (div < min_div) ? min_div : div;
    return 2 * d + (odd ? 1 : 0);
  endfunction

endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             odd,
  input  logic             cpol,
  output logic             sck,
  output logic             shift_evt
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;
  logic             bclk;
  logic             wrap;

  assign half = CNT_W'(i2s_tx_pkg::half_cycles(int'(div), odd, MIN_DIV));
  assign wrap = en && (cnt >= half - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // data moves on the internal falling edge
  assign shift_evt = wrap && bclk;
  assign sck       = bclk ^ cpol;
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         shift_evt,
  input  logic         buf_full,
  input  logic [W-1:0] buf_data,
  input  logic         buf_chan,
  output logic         take,
  output logic         word_done,
  output logic         sd,
  output logic         ws,
  output logic         busy
);
  import i2s_tx_pkg::*;
  localparam int BC_W = $clog2(W);

  sh_state_t     state;
  logic [W-1:0]  sh;
  logic [BC_W-1:0] bitcnt;
  logic          wchan;
  logic          last_bit;

  assign last_bit  = (bitcnt == BC_W'(W - 1));
  assign word_done = (state == SH_SHIFT) && shift_evt && last_bit;
  assign take      = en && buf_full && ((state == SH_IDLE) || word_done);
  assign busy      = (state == SH_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state  <= SH_IDLE;
      sh     <= '0;
      bitcnt <= '0;
      wchan  <= 1'b0;
      sd     <= 1'b0;
      ws     <= 1'b0;
    end else begin
      case (state)
        SH_IDLE: if (take) begin
          sh    <= buf_data;
          wchan <= buf_chan;
          state <= SH_ARM;
        end
        SH_ARM: if (shift_evt) begin
          ws    <= wchan;
          state <= SH_LEAD;
        end
        SH_LEAD: if (shift_evt) begin
          sd     <= sh[W-1];
          sh     <= {sh[W-2:0], 1'b0};
          bitcnt <= '0;
          state  <= SH_SHIFT;
        end
        default: if (shift_evt) begin
          if (last_bit) begin
            bitcnt <= '0;
            if (take) begin
              sd    <= buf_data[W-1];
              sh    <= {buf_data[W-2:0], 1'b0};
              wchan <= buf_chan;
            end else begin
              sd    <= 1'b0;
              state <= SH_IDLE;
            end
          end else begin
            sd     <= sh[W-1];
            sh     <= {sh[W-2:0], 1'b0};
            bitcnt <= bitcnt + BC_W'(1);
            if (bitcnt == BC_W'(W - 2)) ws <= ~wchan;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_odd,
  input  logic              cfg_cpol,
  input  logic              irq_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sck,
  output logic              ws,
  output logic              sd,
  output logic              tx_empty,
  output logic              chan_side,
  output logic              busy,
  output logic              irq
);
  logic              shift_evt;
  logic              word_done;
  logic              take;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;

  i2s_bclk_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .div(cfg_div), .odd(cfg_odd),
    .cpol(cfg_cpol), .sck(sck), .shift_evt(shift_evt)
  );

  i2s_tx_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .shift_evt(shift_evt),
    .buf_full(buf_full), .buf_data(buf_data), .buf_chan(chan_side),
    .take(take), .word_done(word_done), .sd(sd), .ws(ws), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_en) begin
      buf_full  <= 1'b0;
      buf_data  <= '0;
      chan_side <= 1'b0;
    end else begin
      if (take) chan_side <= ~chan_side;
      if (wr_stb) begin
        buf_full <= 1'b1;
        buf_data <= wr_data;
      end else if (take) begin
        buf_full <= 1'b0;
      end
    end
  end

  assign tx_empty = ~buf_full;
  assign irq      = irq_en & tx_empty;
endmodule

// File: rtl/i2s_tx_master_chk.sv
module i2s_tx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_cpol,
  input logic irq_en,
  input logic tx_empty,
  input logic chan_side,
  input logic busy,
  input logic sd,
  input logic ws,
  input logic sck,
  input logic irq,
  input logic shift_evt,
  input logic word_done
);
  // R5: channel flag flips with each rise of tx_empty
  p_chan_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && $past(cfg_en) && $rose(tx_empty)) |-> (chan_side != $past(chan_side)));

  // R5: channel flag holds otherwise
  p_chan_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && $past(cfg_en) && !$rose(tx_empty)) |-> $stable(chan_side));

  // R6: word select only moves on a data-shift event
  p_ws_at_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && $past(cfg_en) && !$past(shift_evt)) |-> $stable(ws));

  // R4: a pending word keeps the stream busy across the boundary
  p_no_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && word_done && !tx_empty) |=> busy);

  // R9: data line quiet when not shifting
  p_quiet_sd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sd);

  // R8: resting clock level while disabled
  p_idle_sck_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !$past(cfg_en)) |-> (sck == cfg_cpol));

  // R10: interrupt follows empty buffer and enable
  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && tx_empty) |-> irq);
endmodule

bind i2s_tx_master i2s_tx_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
  .irq_en(irq_en), .tx_empty(tx_empty), .chan_side(chan_side), .busy(busy),
  .sd(sd), .ws(ws), .sck(sck), .irq(irq), .shift_evt(shift_evt),
  .word_done(word_done)
);

// File: tb/i2s_tx_master_tb.sv
module i2s_tx_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [7:0]  cfg_div = 8'd2;
  logic        cfg_odd = 1'b0;
  logic        cfg_cpol = 1'b0;
  logic        irq_en = 1'b0;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_data = '0;
  logic sck, ws, sd, tx_empty, chan_side, busy, irq;

  always #2 clk = ~clk;

  i2s_tx_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_div(cfg_div),
    .cfg_odd(cfg_odd), .cfg_cpol(cfg_cpol), .irq_en(irq_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .sck(sck), .ws(ws), .sd(sd), .tx_empty(tx_empty),
    .chan_side(chan_side), .busy(busy), .irq(irq)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  int exp_q[$];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int div, input int odd);
    int d;
    d = (div < 2) ? 2 : div;
    return 2 * (2 * d + odd);
  endfunction

  // driver: wait for room, record expectation, strobe
  task automatic send(input logic [15:0] d);
    while (!tx_empty) @(negedge clk);
    exp_q.push_back({15'd0, chan_side, d});
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  // monitor state
  logic prev_sck = 1'b0, prev_busy = 1'b0, prev_te = 1'b1, prev_chan = 1'b0, prev_en = 1'b0;
  logic ws_before = 1'b0, ws_last_rise = 1'b0, ws_msb = 1'b0;
  logic [15:0] rx = '0;
  int nbits = 0;
  int words_seen = 0;
  int gap_errs = 0;
  int chan_errs = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sck && !prev_sck && !cfg_cpol) begin
        if (busy) begin
          if (nbits == 0) begin
            ws_before = ws_last_rise;
            ws_msb    = ws;
          end
          rx = {rx[14:0], sd};
          nbits++;
          if (nbits == 16) begin
            nbits = 0;
            words_seen++;
            if (exp_q.size() == 0) chk("R3 unexpected word", int'(rx), -1);
            else begin
              int e;
              e = exp_q.pop_front();
              chk("R3 word data", int'(rx), e & 16'hFFFF);
              chk("R6 ws before msb", int'(ws_before), (e >> 16) & 1);
              chk("R6 ws at msb", int'(ws_msb), (e >> 16) & 1);
            end
          end
        end else nbits = 0;
        ws_last_rise = ws;
      end
      if (prev_busy && !busy && !tx_empty && cfg_en) gap_errs++;
      if (cfg_en && prev_en) begin
        if (!prev_te && tx_empty) begin
          if (chan_side == prev_chan) chan_errs++;
        end else if (chan_side != prev_chan) chan_errs++;
      end
    end
    prev_sck  = sck;
    prev_busy = busy;
    prev_te   = tx_empty;
    prev_chan = chan_side;
    prev_en   = cfg_en;
  end

  task automatic measure(input int div, input int odd);
    int n;
    cfg_en = 1'b0;
    cfg_div = 8'(div);
    cfg_odd = odd[0];
    @(negedge clk);
    cfg_en = 1'b1;
    while (sck) @(negedge clk);
    while (!sck) @(negedge clk);
    n = 0;
    while (sck) begin @(negedge clk); n++; end
    while (!sck) begin @(negedge clk); n++; end
    chk($sformatf("R7 period div=%0d odd=%0d", div, odd), n, exp_period(div, odd));
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset tx_empty", int'(tx_empty), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset chan_side", int'(chan_side), 0);
    chk("R1 reset sd", int'(sd), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R8 idle sck cpol0", int'(sck), 0);
    cfg_cpol = 1'b1;
    @(negedge clk);
    chk("R8 idle sck cpol1", int'(sck), 1);
    cfg_cpol = 1'b0;

    // R11: strobe while disabled
    wr_data = 16'hDEAD; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    chk("R11 disabled write ignored", int'(tx_empty), 1);
    @(negedge clk);
    chk("R11 disabled write ignored busy", int'(busy), 0);

    measure(2, 0);
    measure(3, 1);
    measure(0, 0);
    measure(5, 0);

    cfg_en = 1'b0; cfg_div = 8'd2; cfg_odd = 1'b0;
    @(negedge clk);
    cfg_en = 1'b1;
    @(negedge clk);
    chk("R1 enabled tx_empty", int'(tx_empty), 1);
    chk("R1 enabled chan_side", int'(chan_side), 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10 irq when empty", int'(irq), 1);

    // R2: write into idle shifter
    exp_q.push_back({15'd0, chan_side, 16'hA55A});
    wr_data = 16'hA55A; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    chk("R2 empty low one cycle", int'(tx_empty), 0);
    chk("R10 irq low when full", int'(irq), 0);
    chk("R5 chan before load", int'(chan_side), 0);
    @(negedge clk);
    chk("R2 empty high again", int'(tx_empty), 1);
    chk("R5 chan after load", int'(chan_side), 1);

    // R4: second word waits in buffer
    send(16'h1234);
    repeat (40) @(negedge clk);
    chk("R4 buffer held", int'(tx_empty), 0);
    chk("R4 busy while shifting", int'(busy), 1);
    send(16'hFFFF);
    send(16'h0001);
    send(16'h8000);
    drain();
    repeat (4) @(negedge clk);
    chk("R9 busy low after drain", int'(busy), 0);
    chk("R9 empty after drain", int'(tx_empty), 1);
    chk("R4 no gap between words", gap_errs, 0);

    // R9: isolated word busy length
    begin
      int n;
      send(16'h0F0F);
      while (!busy) @(negedge clk);
      n = 0;
      while (busy) begin @(negedge clk); n++; end
      chk("R9 busy length single word", n, 16 * exp_period(2, 0));
    end
    send(16'hC3C3);
    drain();
    repeat (4) @(negedge clk);
    chk("R3 words received", words_seen, 7);
    chk("R5 chan flag timing", chan_errs, 0);
    chk("R5 chan after seven loads", int'(chan_side), 1);

    // R11: disable clears channel side
    cfg_en = 1'b0;
    @(negedge clk);
    cfg_en = 1'b1;
    @(negedge clk);
    chk("R11 chan reset by disable", int'(chan_side), 0);
    chk("R11 empty after re-enable", int'(tx_empty), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule